// File: doc/BRIEF.md
# MAC-to-PHY Parallel Port Arbiter

This block shares one 16-bit parallel word port between three MAC-side requesters and the PHY. It also runs the strobe/acknowledge handshake that moves each word. The three requesters are outgoing frame words, control commands and incoming frame words. Only one word moves at a time. A fixed-priority state machine chooses which requester is served next, and it chooses again after every word.

A control command is a word written to the PHY. The arbiter then reads one word back from the PHY, and the write and the read-back form one sequence that no other requester can break into. The read-back word is kept in a holding register and flagged with a one-cycle valid pulse.

The bus is split into an outgoing word, an output enable and an incoming word, so the tri-state driver can sit at the chip pad. Whenever the transfer direction changes, the port is released for at least one cycle. After reset the arbiter waits a set number of cycles before it serves anyone. If the PHY does not acknowledge a word within a bounded wait, the arbiter raises an error pulse and returns to idle.

Top module: `pport_arbiter`

## Requirements
- R1: After the synchronous reset is released, no strobe is issued for at least STALL_CYC cycles. A request that is pending from reset is then served within a few cycles.
- R2: When the idle arbiter sees several requests, an outgoing frame word is served before any other word.
- R3: A control command is served before an incoming frame word.
- R4: Incoming frame words are served only when neither of the other two requesters is pending. The word returned by the PHY appears on rx_word together with a one-cycle rx_valid pulse.
- R5: Each control write is followed at once by one read from the PHY, and no other transfer comes between them. The word read is presented on rb_word, and rb_valid and ctl_done pulse together for one cycle.
- R6: bus_oe is high only during a write strobe (phy_stb=1 with phy_wr=1). While it is high, bus_dout carries the requester's word.
- R7: A read strobe never follows a cycle in which bus_oe was high. A write strobe never directly follows a read-strobe cycle.
- R8: phy_stb stays high until phy_ack is sampled high. The matching completion pulse (tx_done, ctl_done or rx_valid) appears in the next cycle, and at most one completion or error pulse is high in any cycle.
- R9: If phy_ack stays low for TO_CYC strobe cycles, the strobe drops after exactly TO_CYC cycles. A one-cycle to_err pulse follows, no completion pulse is given, and the arbiter goes back to idle.
- R10: A requester that keeps its request high is served word after word. A higher-priority request that arrives during such a burst is served at the next word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Outgoing frame word pending |
| tx_word | input | DW | Outgoing frame word |
| tx_done | output | 1 | Outgoing word accepted by the PHY |
| ctl_req | input | 1 | Control command pending |
| ctl_word | input | DW | Control word to write |
| ctl_done | output | 1 | Control write plus read-back complete |
| rb_word | output | DW | Word read back after a control write |
| rb_valid | output | 1 | rb_word updated |
| rx_req | input | 1 | Incoming frame word wanted |
| rx_word | output | DW | Incoming frame word |
| rx_valid | output | 1 | rx_word updated |
| bus_dout | output | DW | Word driven toward the PHY |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_din | input | DW | Word returned by the PHY |
| phy_stb | output | 1 | Transfer strobe |
| phy_wr | output | 1 | Transfer direction, 1 = write |
| phy_ack | input | 1 | PHY acknowledge |
| to_err | output | 1 | Handshake timeout pulse |

## Verification
The bench runs every combination of the three requesters, each asking for two words, against PHY acknowledge latencies of zero to two cycles. From the order of the completions it can tell a correct fixed priority from a swapped or round-robin one. An incoming-frame burst that is interrupted by a late outgoing word separates re-arbitration at word boundaries from a burst that holds the bus to the end. A late outgoing request raised during a control write shows whether the read-back is atomic. A PHY that never acknowledges pins the length of the timeout window to the exact cycle.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [2:0] {
    S_STALL,
    S_IDLE,
    S_TURN,
    S_TXW,
    S_CTLW,
    S_RBR,
    S_RXR
  } pport_st_e;

  localparam int NREQ    = 3;
  localparam int IDX_TX  = 0;
  localparam int IDX_CTL = 1;
  localparam int IDX_RX  = 2;
endpackage

// File: rtl/pport_prio.sv
module pport_prio #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // lowest index wins
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pport_stall.sv
module pport_stall #(
  parameter int STALL_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int SW = $clog2(STALL_CYC + 1);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= SW'(STALL_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pport_hs_timer.sv
module pport_hs_timer #(
  parameter int TO_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ack,
  output logic expire
);
  localparam int CW = (TO_CYC > 1) ? $clog2(TO_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TO_CYC - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && !ack && (cnt_q == LAST);
endmodule

// File: rtl/pport_arbiter.sv
module pport_arbiter
  import pport_pkg::*;
#(
  parameter int DW        = 16,
  parameter int STALL_CYC = 8,
  parameter int TO_CYC    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_req,
  input  logic [DW-1:0] tx_word,
  output logic          tx_done,
  input  logic          ctl_req,
  input  logic [DW-1:0] ctl_word,
  output logic          ctl_done,
  output logic [DW-1:0] rb_word,
  output logic          rb_valid,
  input  logic          rx_req,
  output logic [DW-1:0] rx_word,
  output logic          rx_valid,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din,
  output logic          phy_stb,
  output logic          phy_wr,
  input  logic          phy_ack,
  output logic          to_err
);
  pport_st_e st_q, st_d, pend_q, pend_d;
  logic dir_q;          // 1: bus last driven by this block
  logic stall_done, expire, xfer_q;
  logic [NREQ-1:0] req_v, gnt_v;
  logic [DW-1:0] data_d;

  assign req_v = {rx_req, ctl_req, tx_req};
  assign xfer_q = (st_q == S_TXW) || (st_q == S_CTLW) ||
                  (st_q == S_RBR) || (st_q == S_RXR);

  pport_prio #(.N(NREQ)) prio_i (.req(req_v), .gnt(gnt_v));

  pport_stall #(.STALL_CYC(STALL_CYC)) stall_i (
    .clk(clk), .rst(rst), .done(stall_done));

  pport_hs_timer #(.TO_CYC(TO_CYC)) tmr_i (
    .clk(clk), .rst(rst), .run(xfer_q), .ack(phy_ack), .expire(expire));

  function automatic logic is_wr(pport_st_e s);
    return (s == S_TXW) || (s == S_CTLW);
  endfunction

  function automatic logic is_xfer(pport_st_e s);
    return (s == S_TXW) || (s == S_CTLW) || (s == S_RBR) || (s == S_RXR);
  endfunction

  always_comb begin
    pport_st_e op;
    st_d   = st_q;
    pend_d = pend_q;
    data_d = bus_dout;
    op     = S_IDLE;
    case (st_q)
      S_STALL: if (stall_done) st_d = S_IDLE;
      S_IDLE: begin
        if (gnt_v[IDX_TX]) begin
          op = S_TXW;  data_d = tx_word;
        end else if (gnt_v[IDX_CTL]) begin
          op = S_CTLW; data_d = ctl_word;
        end else if (gnt_v[IDX_RX]) begin
          op = S_RXR;
        end
        if (op != S_IDLE) begin
          if (is_wr(op) == dir_q) st_d = op;
          else begin
            st_d   = S_TURN;
            pend_d = op;
          end
        end
      end
      S_TURN: st_d = pend_q;
      S_CTLW: begin
        if (phy_ack) begin
          st_d   = S_TURN;    // locked read-back follows
          pend_d = S_RBR;
        end else if (expire) st_d = S_IDLE;
      end
      S_TXW, S_RBR, S_RXR: begin
        if (phy_ack || expire) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_STALL;
      pend_q   <= S_IDLE;
      dir_q    <= 1'b0;
      bus_dout <= '0;
      bus_oe   <= 1'b0;
      phy_stb  <= 1'b0;
      phy_wr   <= 1'b0;
      tx_done  <= 1'b0;
      ctl_done <= 1'b0;
      rb_valid <= 1'b0;
      rb_word  <= '0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
      to_err   <= 1'b0;
    end else begin
      st_q     <= st_d;
      pend_q   <= pend_d;
      bus_dout <= data_d;
      if (is_xfer(st_d)) dir_q <= is_wr(st_d);
      phy_stb  <= is_xfer(st_d);
      phy_wr   <= is_wr(st_d);
      bus_oe   <= is_wr(st_d);
      tx_done  <= (st_q == S_TXW) && phy_ack;
      ctl_done <= (st_q == S_RBR) && phy_ack;
      rb_valid <= (st_q == S_RBR) && phy_ack;
      rx_valid <= (st_q == S_RXR) && phy_ack;
      to_err   <= expire;
      if ((st_q == S_RBR) && phy_ack) rb_word <= bus_din;
      if ((st_q == S_RXR) && phy_ack) rx_word <= bus_din;
    end
  end

  // R1: quiet during the reset stall
  assert_stall_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !stall_done |-> !phy_stb);

  // R6: drive only in write strobes
  assert_oe_write_R6: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (phy_stb && phy_wr));

  // R7: released cycle on every direction change
  assert_turn_rd_R7: assert property (@(posedge clk) disable iff (rst)
    (phy_stb && !phy_wr) |-> !$past(bus_oe));
  assert_turn_wr_R7: assert property (@(posedge clk) disable iff (rst)
    (phy_stb && phy_wr) |-> !$past(phy_stb && !phy_wr));

  // R8: one completion event per cycle
  assert_done_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_done, ctl_done, rx_valid, to_err}));

  // R9: error only after an unanswered strobe
  assert_timeout_R9: assert property (@(posedge clk) disable iff (rst)
    to_err |-> ($past(phy_stb) && !$past(phy_ack)));

  // R5: read-back begins right after the control write's turnaround
  assert_rb_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_RBR && $past(st_q) != S_RBR) |-> $past(pend_q == S_RBR));
endmodule

// File: tb/pport_arbiter_tb.sv
module pport_arbiter_tb_top;
  localparam int DW = 16;
  localparam int STALL_CYC = 8;
  localparam int TO_CYC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic tx_req, ctl_req, rx_req;
  logic [DW-1:0] tx_word, ctl_word, rb_word, rx_word, bus_dout;
  logic [DW-1:0] bus_din = '0;
  logic phy_ack = 1'b0;
  logic tx_done, ctl_done, rb_valid, rx_valid, bus_oe, phy_stb, phy_wr, to_err;

  int tx_left = 0, ctl_left = 0, rx_left = 0;
  int tx_idx = 0, ctl_idx = 0;
  int lat = 0;
  bit noack = 1'b0;
  int scnt = 0;
  int rdn = 0;
  logic [DW-1:0] last_wr = '0, rd_last = '0, rd_last_wr = '0;
  int code_log[64];
  int logn = 0;
  logic [DW-1:0] wlog[64];
  int wn = 0;
  int stbcnt = 0, errs_seen = 0;
  int viol6 = 0, viol7 = 0;
  logic prev_oe = 1'b0, prev_rd = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign tx_req  = (tx_left > 0);
  assign ctl_req = (ctl_left > 0);
  assign rx_req  = (rx_left > 0);
  assign tx_word  = 16'(32'h1100 + tx_idx);
  assign ctl_word = 16'(32'h2200 + ctl_idx);

  pport_arbiter #(.DW(DW), .STALL_CYC(STALL_CYC), .TO_CYC(TO_CYC)) dut_i (
    .clk(clk), .rst(rst),
    .tx_req(tx_req), .tx_word(tx_word), .tx_done(tx_done),
    .ctl_req(ctl_req), .ctl_word(ctl_word), .ctl_done(ctl_done),
    .rb_word(rb_word), .rb_valid(rb_valid),
    .rx_req(rx_req), .rx_word(rx_word), .rx_valid(rx_valid),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
    .phy_stb(phy_stb), .phy_wr(phy_wr), .phy_ack(phy_ack), .to_err(to_err));

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY stand-in, completion bookkeeping and bus monitors
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_oe && !(phy_stb && phy_wr)) viol6++;
      if (phy_stb && !phy_wr && prev_oe) viol7++;
      if (phy_stb && phy_wr && prev_rd) viol7++;
      if (phy_stb && phy_wr && bus_dout != last_wr && scnt == 0) begin end
      prev_oe = bus_oe;
      prev_rd = phy_stb && !phy_wr;
      if (phy_stb) stbcnt++;
    end
    if (phy_stb && !noack) begin
      if (scnt == lat) begin
        phy_ack <= 1'b1;
        if (phy_wr) begin
          last_wr = bus_dout;
          if (wn < 64) wlog[wn] = bus_dout;
          wn++;
        end else begin
          rd_last = last_wr ^ {rdn[7:0], 8'h5A};
          rd_last_wr = last_wr;
          bus_din <= rd_last;
          rdn++;
        end
      end else phy_ack <= 1'b0;
      scnt++;
    end else begin
      phy_ack <= 1'b0;
      scnt = 0;
    end
    if (tx_done) begin
      if (logn < 64) code_log[logn] = 1;
      logn++; tx_idx++; tx_left--;
    end
    if (ctl_done) begin
      chk("R5", "read-back word", rb_word, rd_last);
      chk("R5", "write before read-back", rd_last_wr, 16'(32'h2200 + ctl_idx));
      chk("R5", "rb_valid with ctl_done", rb_valid, 1);
      if (logn < 64) code_log[logn] = 2;
      logn++; ctl_idx++; ctl_left--;
    end
    if (rx_valid) begin
      chk("R4", "rx word", rx_word, rd_last);
      if (logn < 64) code_log[logn] = 3;
      logn++; rx_left--;
    end
    if (to_err) begin
      errs_seen++;
      tx_left = 0; ctl_left = 0; rx_left = 0;
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic wait_quiet;
    while (tx_left != 0 || ctl_left != 0 || rx_left != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic run_case(input int nt, input int nc, input int nr, input int l);
    int exp_codes[64];
    int k;
    @(negedge clk);
    logn = 0; wn = 0; tx_idx = 0; ctl_idx = 0;
    lat = l;
    tx_left = nt; ctl_left = nc; rx_left = nr;
    wait_quiet();
    k = 0;
    for (int i = 0; i < nt; i++) begin exp_codes[k] = 1; k++; end
    for (int i = 0; i < nc; i++) begin exp_codes[k] = 2; k++; end
    for (int i = 0; i < nr; i++) begin exp_codes[k] = 3; k++; end
    chk("R8", "completion count", logn, k);
    for (int i = 0; i < k && i < logn; i++)
      chk("R2 R3 R4", "service order", code_log[i], exp_codes[i]);
    chk("R6", "write count", wn, nt + nc);
    for (int i = 0; i < nt && i < wn; i++)
      chk("R6", "tx word on bus", wlog[i], 16'(32'h1100 + i));
    for (int i = 0; i < nc && nt + i < wn; i++)
      chk("R6", "ctl word on bus", wlog[nt + i], 16'(32'h2200 + i));
  endtask

  initial begin
    int k;
    tx_left = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "outputs idle in reset", {phy_stb, bus_oe, tx_done, to_err}, 0);
    rst = 1'b0;
    k = 0;
    while (!phy_stb && k < 40) begin @(negedge clk); k++; end
    chk("R1", "quiet cycles at least stall", (k >= STALL_CYC), 1);
    chk("R1", "first strobe soon after stall", (k <= STALL_CYC + 6), 1);
    wait_quiet();

    // sweep every requester mix against several ack latencies
    for (int l = 0; l < 3; l++)
      for (int m = 1; m < 8; m++)
        run_case(m[0] ? 2 : 0, m[1] ? 2 : 0, m[2] ? 2 : 0, l);

    // R10: outgoing word preempts an incoming burst at a word boundary
    @(negedge clk);
    logn = 0; wn = 0; tx_idx = 0; lat = 0;
    rx_left = 4;
    while (logn < 1) @(posedge clk);
    @(negedge clk);
    tx_left = 1;
    wait_quiet();
    chk("R10", "burst length", logn, 5);
    chk("R10", "word 0", code_log[0], 3);
    chk("R10", "word 1", code_log[1], 3);
    chk("R10", "preempting word", code_log[2], 1);
    chk("R10", "word 3", code_log[3], 3);
    chk("R10", "word 4", code_log[4], 3);

    // R5: outgoing request raised mid control write waits for read-back
    @(negedge clk);
    logn = 0; wn = 0; ctl_idx = 0; tx_idx = 0; lat = 2;
    ctl_left = 1;
    while (!(phy_stb && phy_wr)) @(posedge clk);
    @(negedge clk);
    tx_left = 1;
    wait_quiet();
    chk("R5", "sequence length", logn, 2);
    chk("R5", "control sequence first", code_log[0], 2);
    chk("R5", "outgoing word after", code_log[1], 1);

    // R9: unanswered strobe
    @(negedge clk);
    logn = 0; errs_seen = 0; noack = 1'b1; lat = 0;
    tx_left = 1;
    while (!phy_stb) @(posedge clk);
    @(negedge clk);
    stbcnt = 1;
    while (errs_seen == 0) @(negedge clk);
    chk("R9", "strobe cycles before timeout", stbcnt, TO_CYC);
    chk("R9", "no completion", logn, 0);
    chk("R9", "strobe released", phy_stb, 0);
    noack = 1'b0;
    repeat (4) @(posedge clk);
    chk("R9", "single error pulse", errs_seen, 1);
    run_case(1, 1, 1, 1);
    chk("R9", "service resumes", logn, 3);

    chk("R6", "drive outside write strobe", viol6, 0);
    chk("R7", "missing turnaround", viol7, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule